// File: doc/BRIEF.md
# Fault-Driven Soft-Start Restart Sequencer

This block decides when a switching power stage may drive its switch, and how wide each pulse may be while the converter comes up. A soft-start counter stands in for the ramp capacitor. When operation starts, the counter climbs, and the duty ceiling rises with it from 0% up to a full-scale code. That code stands for the 72% maximum duty.

Every input is already digital and synchronous to `clk`. The block sees two supply-level flags, the overvoltage, undervoltage and shutdown-timer comparators, and a severe-overcurrent flag. A fault removes the output enable and pulses a resync request so that the downstream PWM returns to its internal oscillator. The counter then discharges below a low level before a new ramp begins.

Overvoltage and shutdown-timer faults also set a shutdown latch. While that latch is set, no restart happens. Only a supply lockout followed by a fresh enable clears it. The supply enable has hysteresis: one flag turns the block on and a separate, lower flag turns it off. While the block is locked out, it also asks the external shutdown timer to clear.

Top module: `ss_restart_seq`

## Requirements
- R1: The supply enable is hysteretic. It turns on when `sup_on` is high and turns off when `sup_off` is high. With both flags low it keeps its state. `tmr_clr` is high exactly while the block is disabled.
- R2: While disabled, the outputs are held as follows: `out_en` = 0, `duty_ceil` = 0, `resync` = 0 and `shut_latched` = 0. The ramp counter is also held at zero.
- R3: On the clock edge that enables the block, `out_en` becomes 1. The ramp then adds `CHG_STEP` on each later edge. `duty_ceil` is the ramp minus `LOW_LVL` when the ramp is above `LOW_LVL`, and 0 otherwise.
- R4: The ramp saturates at `RAMP_FULL`, so `duty_ceil` never exceeds `RAMP_FULL - LOW_LVL`. That value is the code for the 72% duty maximum.
- R5: While running, any of `ov`, `uv`, `sd_trip` or `oc_hi` clears `out_en` on the next edge. On that same edge `resync` goes high for exactly one cycle.
- R6: After a fault, the ramp falls by `DIS_STEP` per edge, stopping at 0. `out_en` stays low until the ramp is below `LOW_LVL` with no fault present. On the next edge `out_en` returns, and the ramp restarts from the value it had reached.
- R7: A severe-overcurrent fault on its own does not latch. Once its discharge is complete, the block restarts by itself.
- R8: `ov` or `sd_trip` sets `shut_latched` while the block is enabled. The latch holds `out_en` low and the ramp discharging until a lockout occurs. A later re-enable then restarts normally.
- R9: `uv` forces the ramp to 0 on the next edge and keeps `out_en` low while it stays high. Once it clears, the block restarts on the next edge.
- R10: When `sup_on` and `sup_off` are high together, the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_on | input | 1 | Supply above the turn-on level |
| sup_off | input | 1 | Supply below the turn-off level |
| ov | input | 1 | Input overvoltage comparator |
| uv | input | 1 | Input undervoltage comparator |
| sd_trip | input | 1 | Shutdown-timer threshold comparator |
| oc_hi | input | 1 | Severe overcurrent comparator |
| out_en | output | 1 | Switch drive permitted |
| duty_ceil | output | RAMP_W | Duty ceiling code, 0 to RAMP_FULL-LOW_LVL |
| resync | output | 1 | One-cycle request to return to oscillator control |
| shut_latched | output | 1 | Latched shutdown status |
| tmr_clr | output | 1 | Lockout active; clear the external shutdown timer |

## Verification
The assertions assume every comparator input is already synchronised and free of glitches. Each input is sampled only at a rising clock edge. They also assume that the two supply flags can be asserted together, and that this case resolves to off. The stimulus changes inputs one time unit after a clock edge and then holds them for a full cycle. Faults, supply flags and their combinations are applied as cycle-wide levels, never as pulses shorter than a clock period.

// File: rtl/ss_restart_seq.sv
module ss_restart_seq #(
  parameter int RAMP_W    = 10,
  parameter int RAMP_FULL = 1000,
  parameter int LOW_LVL   = 200,
  parameter int CHG_STEP  = 7,
  parameter int DIS_STEP  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sup_on,
  input  logic              sup_off,
  input  logic              ov,
  input  logic              uv,
  input  logic              sd_trip,
  input  logic              oc_hi,
  output logic              out_en,
  output logic [RAMP_W-1:0] duty_ceil,
  output logic              resync,
  output logic              shut_latched,
  output logic              tmr_clr
);
  localparam logic [RAMP_W:0]   FULL_X = (RAMP_W+1)'(RAMP_FULL);
  localparam logic [RAMP_W-1:0] FULL_C = RAMP_W'(RAMP_FULL);
  localparam logic [RAMP_W-1:0] LOW_C  = RAMP_W'(LOW_LVL);
  localparam logic [RAMP_W-1:0] CHG_C  = RAMP_W'(CHG_STEP);
  localparam logic [RAMP_W-1:0] DIS_C  = RAMP_W'(DIS_STEP);
  localparam logic [RAMP_W-1:0] DMAX   = RAMP_W'(RAMP_FULL - LOW_LVL);

  typedef enum logic {M_DISCH, M_RUN} mode_t;

  logic              en_q;
  mode_t             mode;
  logic [RAMP_W-1:0] ramp;
  logic              latch_q;

  wire en_nx  = en_q ? ~sup_off : (sup_on & ~sup_off);
  wire trip   = ov | sd_trip;
  wire fault  = ov | uv | sd_trip | oc_hi | latch_q;

  wire [RAMP_W:0]   up_x    = {1'b0, ramp} + {1'b0, CHG_C};
  wire [RAMP_W-1:0] ramp_up = (up_x > FULL_X) ? FULL_C : up_x[RAMP_W-1:0];
  wire [RAMP_W-1:0] ramp_dn = uv ? '0 : ((ramp < DIS_C) ? '0 : ramp - DIS_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mode    <= M_DISCH;
      ramp    <= '0;
      latch_q <= 1'b0;
      resync  <= 1'b0;
    end else begin
      en_q   <= en_nx;
      resync <= 1'b0;
      if (!en_nx) begin
        mode    <= M_DISCH;
        ramp    <= '0;
        latch_q <= 1'b0;
      end else begin
        if (trip) latch_q <= 1'b1;
        case (mode)
          M_RUN: begin
            if (fault) begin
              mode   <= M_DISCH;
              resync <= 1'b1;
              ramp   <= ramp_dn;
            end else begin
              ramp <= ramp_up;
            end
          end
          default: begin
            if (!fault && ramp < LOW_C) mode <= M_RUN;
            else                        ramp <= ramp_dn;
          end
        endcase
      end
    end
  end

  assign out_en       = (mode == M_RUN);
  assign duty_ceil    = (ramp > LOW_C) ? ramp - LOW_C : '0;
  assign shut_latched = latch_q;
  assign tmr_clr      = ~en_q;

  // R2
  lockout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr |-> (!out_en && duty_ceil == '0 && !shut_latched && !resync));

  // R1
  hyst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_clr && !sup_on) |=> tmr_clr);

  // R10
  off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sup_off |=> tmr_clr);

  // R4
  ceil_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    duty_ceil <= DMAX);

  // R3
  ramp_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |=> (!out_en || duty_ceil >= $past(duty_ceil)));

  // R5
  fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && (ov || uv || sd_trip || oc_hi)) |=> (!out_en && (resync || tmr_clr)));

  // R5
  resync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !resync);

  // R8
  latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shut_latched |=> (shut_latched || tmr_clr));

  // R8
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ov || sd_trip) && !tmr_clr && !sup_off) |=> shut_latched);

  // R8
  latch_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shut_latched |-> !out_en);

  // R9
  uv_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv |=> (!out_en && duty_ceil == '0));
endmodule

// File: tb/sim_ss_restart_seq.sv
module sim_ss_restart_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_on = 0, sup_off = 0, ov = 0, uv = 0, sd_trip = 0, oc_hi = 0;
  logic       out_en, resync, shut_latched, tmr_clr;
  logic [7:0] duty_ceil;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ss_restart_seq #(.RAMP_W(8), .RAMP_FULL(40), .LOW_LVL(10), .CHG_STEP(7), .DIS_STEP(5)) u0 (
    .clk(clk), .rst_n(rst_n), .sup_on(sup_on), .sup_off(sup_off), .ov(ov), .uv(uv),
    .sd_trip(sd_trip), .oc_hi(oc_hi), .out_en(out_en), .duty_ceil(duty_ceil),
    .resync(resync), .shut_latched(shut_latched), .tmr_clr(tmr_clr));

  // inputs {on,off,ov,uv,sd,oc}, outputs {out_en,resync,latched,tmr_clr}, duty
  localparam int NV = 31;
  localparam logic [17:0] VEC [NV] = '{
    {6'b000000, 4'b0001, 8'd0},  {6'b100000, 4'b1000, 8'd0},
    {6'b000000, 4'b1000, 8'd0},  {6'b000000, 4'b1000, 8'd4},
    {6'b000000, 4'b1000, 8'd11}, {6'b000000, 4'b1000, 8'd18},
    {6'b000000, 4'b1000, 8'd25}, {6'b000000, 4'b1000, 8'd30},
    {6'b000000, 4'b1000, 8'd30}, {6'b000001, 4'b0100, 8'd25},
    {6'b000000, 4'b0000, 8'd20}, {6'b000000, 4'b0000, 8'd15},
    {6'b000000, 4'b0000, 8'd10}, {6'b000000, 4'b0000, 8'd5},
    {6'b000000, 4'b0000, 8'd0},  {6'b000000, 4'b0000, 8'd0},
    {6'b000000, 4'b1000, 8'd0},  {6'b000000, 4'b1000, 8'd2},
    {6'b000100, 4'b0100, 8'd0},  {6'b000100, 4'b0000, 8'd0},
    {6'b000000, 4'b1000, 8'd0},  {6'b000000, 4'b1000, 8'd0},
    {6'b001000, 4'b0110, 8'd0},  {6'b000000, 4'b0010, 8'd0},
    {6'b000000, 4'b0010, 8'd0},  {6'b010000, 4'b0001, 8'd0},
    {6'b000000, 4'b0001, 8'd0},  {6'b100000, 4'b1000, 8'd0},
    {6'b000010, 4'b0110, 8'd0},  {6'b000000, 4'b0010, 8'd0},
    {6'b110000, 4'b0001, 8'd0}
  };

  function automatic string req_of(int i);
    if (i <= 1 || i == 26) return "R1";
    if (i == 25)           return "R2";
    if (i <= 6 || i == 21) return "R3";
    if (i <= 8)            return "R4";
    if (i == 9)            return "R5";
    if (i <= 16)           return "R6";
    if (i == 17)           return "R7";
    if (i <= 20)           return "R9";
    if (i == 30)           return "R10";
    return "R8";
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [5:0] v);
    {sup_on, sup_off, ov, uv, sd_trip, oc_hi} = v;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    drive(6'b0);
    repeat (3) tick();
    // R2 reset state
    chk("R2", "reset out_en", out_en, 0);
    chk("R2", "reset tmr_clr", tmr_clr, 1);
    chk("R2", "reset duty", duty_ceil, 0);
    chk("R2", "reset latched", shut_latched, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][17:12]);
      tick();
      chk(req_of(i), $sformatf("v%0d out_en", i), out_en, VEC[i][11]);
      chk(req_of(i), $sformatf("v%0d resync", i), resync, VEC[i][10]);
      chk(req_of(i), $sformatf("v%0d latched", i), shut_latched, VEC[i][9]);
      chk(req_of(i), $sformatf("v%0d tmr_clr", i), tmr_clr, VEC[i][8]);
      chk(req_of(i), $sformatf("v%0d duty", i), duty_ceil, VEC[i][7:0]);
    end

    // R8: overvoltage arriving during an overcurrent discharge still latches
    drive(6'b100000); tick();
    drive(6'b000000); repeat (5) tick();
    chk("R3", "ramp 35 duty", duty_ceil, 25);
    drive(6'b000001); tick();
    chk("R5", "oc resync", resync, 1);
    drive(6'b001000); tick();
    chk("R8", "ov in discharge latched", shut_latched, 1);
    chk("R8", "no second resync", resync, 0);
    drive(6'b000000); repeat (20) tick();
    chk("R8", "latched holds off", out_en, 0);

    // R2: asynchronous reset mid-run
    drive(6'b010000); tick();
    drive(6'b100000); tick();
    drive(6'b000000); repeat (3) tick();
    chk("R3", "running before reset", out_en, 1);
    #2 rst_n = 1'b0; #1;
    chk("R2", "async reset out_en", out_en, 0);
    chk("R2", "async reset tmr_clr", tmr_clr, 1);
    tick();
    rst_n = 1'b1;
    finish_up();
  end
endmodule